// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

This block moves a block of words between an I/O device and memory so that the processor does not run an instruction for each word. Software first writes four things through a small register port: the device number, the first memory address, the number of words, and the direction. It then sets a go bit. The controller takes over from there.

For each word, the controller raises a bus request and waits for the grant. It then spends exactly one bus cycle on that word. In that cycle it drives the memory address, the device number and the direction, and the word passes straight between the device and memory. The controller then advances its address, lowers the count and drops the request for one cycle, which hands the bus back to the processor. It repeats this until the count is exhausted.

At the end it sets a done flag that also drives the interrupt line. The flag stays set until software clears it or starts a new transfer. The processor keeps its own context throughout: it is only held off the bus during the stolen cycles.

Top module: `csdma_ctrl`

## Requirements
- R1: After reset, `bus_req`, `bus_xfer` and `irq` are low, and the status, memory-address and count registers read as zero.
- R2: A word cycle (`bus_xfer` high) begins only on the clock after `bus_req` was high and `bus_gnt` was sampled high. While no grant is sampled, the request is held.
- R3: Each grant moves exactly one word. `bus_xfer` lasts one cycle, and on the next cycle both `bus_xfer` and `bus_req` are low.
- R4: After every word, the memory-address register (offset 2) increases by one, wrapping at its width, and the count register (offset 3) decreases by one. Word k of a transfer uses the start address plus k.
- R5: When the count reaches zero, busy (status bit 0, offset 4) clears, done (status bit 1) sets and `irq` rises. A transfer of N words performs exactly N word cycles.
- R6: Once set, done and `irq` stay high until software clears them or accepts a new start.
- R7: Writing the status register with bit 1 set clears done and `irq`. A status write with bit 1 clear leaves them unchanged.
- R8: While busy, a write with the go bit (control offset 0, bit 0) has no effect. Writes to the device, memory-address, count and direction fields also have no effect; they are taken only when idle.
- R9: A go with a count of zero finishes on the same clock edge: done is set and no bus request is ever raised.
- R10: If the last word completes on the same edge as a status clear, done wins and stays set.
- R11: An accepted go with a non-zero count clears any pending done, so `irq` is low on the following cycle.
- R12: During each word cycle, `bus_dev_addr` carries the programmed device number (offset 1). `bus_mem_to_dev` carries the direction bit (control bit 1; 1 = memory to device), and that bit reads back at control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset (0 control, 1 device, 2 memory address, 3 count, 4 status) |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data for `cfg_addr` (combinational) |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_xfer | output | 1 | High for the single cycle in which one word moves |
| bus_mem_addr | output | AW | Memory address of the current word |
| bus_dev_addr | output | DVW | Device number of the transfer |
| bus_mem_to_dev | output | 1 | Direction: 1 memory to device, 0 device to memory |
| irq | output | 1 | Completion interrupt, level, equals done |

## Verification
Two events can land on one clock edge: completion of the last word, which sets done, and a software status write that clears done. The bench holds the grant open so that a one-word transfer has fixed timing, then lines up the clear write with the edge on which the count-zero gap state retires. It then checks that `irq` is still high afterwards and that a later clear does remove it.

A second overlap is a go whose count is zero, where the start and the completion fall on the same edge. The bench judges that case by `irq` rising with no request ever seen on the bus.

// File: rtl/csdma_pkg.sv
package csdma_pkg;

    // Sequencer states: idle, waiting for grant, word cycle, bus-return gap
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_e;

    // Register offsets
    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_DEV   = 3'd1;
    localparam logic [2:0] REG_MADDR = 3'd2;
    localparam logic [2:0] REG_COUNT = 3'd3;
    localparam logic [2:0] REG_STAT  = 3'd4;

    // Bit positions
    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_DIR_BIT  = 1;
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_DONE_BIT = 1;

endpackage

// File: rtl/csdma_seq.sv
module csdma_seq
    import csdma_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          ld_addr_i,
    input  logic          ld_cnt_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          gnt_i,
    output logic          busy_o,
    output logic          fin_o,
    output logic          req_o,
    output logic          xfer_o,
    output logic [AW-1:0] addr_o,
    output logic [CW-1:0] cnt_o
);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;
    logic     fin_d;

    always_comb begin
        seq_d = seq_q;
        fin_d = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (ld_addr_i) seq_d.addr = wdata_i[AW-1:0];
                if (ld_cnt_i)  seq_d.cnt  = wdata_i[CW-1:0];
                if (go_i) begin
                    if (seq_q.cnt == '0) fin_d = 1'b1;
                    else                 seq_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                if (gnt_i) seq_d.st = ST_XFER;
            end
            ST_XFER: begin
                seq_d.addr = seq_q.addr + AW'(1);
                seq_d.cnt  = seq_q.cnt - CW'(1);
                seq_d.st   = ST_GAP;
            end
            ST_GAP: begin
                if (seq_q.cnt == '0) begin
                    fin_d    = 1'b1;
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.st = ST_REQ;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, addr: '0, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign busy_o = (seq_q.st != ST_IDLE);
    assign req_o  = (seq_q.st == ST_REQ) || (seq_q.st == ST_XFER);
    assign xfer_o = (seq_q.st == ST_XFER);
    assign fin_o  = fin_d;
    assign addr_o = seq_q.addr;
    assign cnt_o  = seq_q.cnt;

    // R2: a word cycle follows a sampled request and grant
    p_xfer_after_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |-> ($past(gnt_i) && $past(req_o)));

    // R2: request held while no grant is seen
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !xfer_o && !gnt_i) |=> (req_o && !xfer_o));

    // R3: one word per grant, then the bus is released
    p_one_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> (!xfer_o && !req_o));

    // R4: address steps up and count steps down after each word
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> ((addr_o == $past(addr_o) + AW'(1)) && (cnt_o == $past(cnt_o) - CW'(1))));

    // R5: completion only with an exhausted count
    p_fin_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> (cnt_o == '0));

    // R8: pointers frozen while busy outside a word cycle
    p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !xfer_o) |=> ($stable(addr_o) && $stable(cnt_o)));

    // R9: a zero-count go never raises the request
    p_zero_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && (cnt_o == '0)) |=> !req_o);

endmodule

// File: rtl/csdma_regs.sv
module csdma_regs
    import csdma_pkg::*;
#(
    parameter int DW  = 16,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int DVW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we_i,
    input  logic [2:0]     addr_i,
    input  logic [DVW-1:0] wlow_i,
    input  logic           busy_i,
    input  logic           fin_i,
    input  logic [AW-1:0]  maddr_i,
    input  logic [CW-1:0]  cnt_i,
    output logic           go_o,
    output logic           ld_addr_o,
    output logic           ld_cnt_o,
    output logic [DVW-1:0] dev_o,
    output logic           dir_o,
    output logic           irq_o,
    output logic [DW-1:0]  rdata_o
);

    typedef struct packed {
        logic [DVW-1:0] dev;
        logic           dir;
        logic           done;
    } cfg_reg_t;

    cfg_reg_t cfg_d, cfg_q;
    logic     wr_ctrl, wr_dev, wr_stat, clr_done;

    always_comb begin
        wr_ctrl   = we_i && (addr_i == REG_CTRL);
        wr_dev    = we_i && (addr_i == REG_DEV);
        wr_stat   = we_i && (addr_i == REG_STAT);
        go_o      = wr_ctrl && wlow_i[CTRL_GO_BIT] && !busy_i;
        ld_addr_o = we_i && (addr_i == REG_MADDR) && !busy_i;
        ld_cnt_o  = we_i && (addr_i == REG_COUNT) && !busy_i;
        clr_done  = wr_stat && wlow_i[STAT_DONE_BIT];

        cfg_d = cfg_q;
        if (wr_ctrl && !busy_i) cfg_d.dir = wlow_i[CTRL_DIR_BIT];
        if (wr_dev && !busy_i)  cfg_d.dev = wlow_i;
        // completion outranks a clear; a new start drops a stale flag
        if (fin_i)         cfg_d.done = 1'b1;
        else if (clr_done) cfg_d.done = 1'b0;
        else if (go_o)     cfg_d.done = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{dev: '0, dir: 1'b0, done: 1'b0};
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            REG_CTRL:  rdata_o[CTRL_DIR_BIT] = cfg_q.dir;
            REG_DEV:   rdata_o = DW'(cfg_q.dev);
            REG_MADDR: rdata_o = DW'(maddr_i);
            REG_COUNT: rdata_o = DW'(cnt_i);
            REG_STAT: begin
                rdata_o[STAT_BUSY_BIT] = busy_i;
                rdata_o[STAT_DONE_BIT] = cfg_q.done;
            end
            default: rdata_o = '0;
        endcase
    end

    assign dev_o = cfg_q.dev;
    assign dir_o = cfg_q.dir;
    assign irq_o = cfg_q.done;

    // R5: completion raises the interrupt
    p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i |=> irq_o);

    // R6: interrupt held without clear or new start
    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_done && !go_o) |=> irq_o);

    // R8: configuration frozen while busy
    p_cfg_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(dev_o) && $stable(dir_o)));

    // R10: completion wins over a simultaneous clear
    p_fin_beats_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_i && clr_done) |=> irq_o);

endmodule

// File: rtl/csdma_ctrl.sv
module csdma_ctrl
    import csdma_pkg::*;
#(
    parameter int DW  = 16,  // register data width
    parameter int AW  = 16,  // memory address width, at most DW
    parameter int CW  = 16,  // word count width, at most DW
    parameter int DVW = 8    // device number width, 2..DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [2:0]     cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           bus_xfer,
    output logic [AW-1:0]  bus_mem_addr,
    output logic [DVW-1:0] bus_dev_addr,
    output logic           bus_mem_to_dev,
    output logic           irq
);

    logic          go, ld_addr, ld_cnt, busy, fin;
    logic [AW-1:0] maddr;
    logic [CW-1:0] cnt;

    csdma_regs #(.DW(DW), .AW(AW), .CW(CW), .DVW(DVW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we),
        .addr_i    (cfg_addr),
        .wlow_i    (cfg_wdata[DVW-1:0]),
        .busy_i    (busy),
        .fin_i     (fin),
        .maddr_i   (maddr),
        .cnt_i     (cnt),
        .go_o      (go),
        .ld_addr_o (ld_addr),
        .ld_cnt_o  (ld_cnt),
        .dev_o     (bus_dev_addr),
        .dir_o     (bus_mem_to_dev),
        .irq_o     (irq),
        .rdata_o   (cfg_rdata)
    );

    csdma_seq #(.DW(DW), .AW(AW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .ld_addr_i (ld_addr),
        .ld_cnt_i  (ld_cnt),
        .wdata_i   (cfg_wdata),
        .gnt_i     (bus_gnt),
        .busy_o    (busy),
        .fin_o     (fin),
        .req_o     (bus_req),
        .xfer_o    (bus_xfer),
        .addr_o    (maddr),
        .cnt_o     (cnt)
    );

    assign bus_mem_addr = maddr;

    // R12: device number and direction steady across a word cycle
    p_bus_fields_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_xfer |-> ($stable(bus_dev_addr) && $stable(bus_mem_to_dev)));

endmodule

// File: tb/csdma_ctrl_test.sv
module csdma_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int NVEC       = 5;
    // {count[16], start address[16], device[8], dir[1], grant latency[4]}
    localparam logic [44:0] VECS [0:NVEC-1] = '{
        {16'd4, 16'h0100, 8'h12, 1'b0, 4'd0},
        {16'd1, 16'h2000, 8'hA5, 1'b1, 4'd3},
        {16'd7, 16'h0FF0, 8'h3C, 1'b1, 4'd1},
        {16'd4, 16'hFFFE, 8'h01, 1'b0, 4'd2},
        {16'd2, 16'h1234, 8'hFF, 1'b1, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        bus_req, bus_gnt, bus_xfer, bus_mem_to_dev, irq;
    logic [15:0] bus_mem_addr;
    logic [7:0]  bus_dev_addr;

    int          n_chk = 0;
    int          n_err = 0;
    int          lat = 0;
    int          wcnt = 0;
    logic [15:0] exp_addr = 16'd0;
    logic [7:0]  exp_dev = 8'd0;
    logic        exp_dir = 1'b0;
    int          xfer_cnt = 0;
    logic        req_seen = 1'b0;
    logic        prev_xfer = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csdma_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_xfer(bus_xfer), .bus_mem_addr(bus_mem_addr),
        .bus_dev_addr(bus_dev_addr), .bus_mem_to_dev(bus_mem_to_dev), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [15:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    // Bus arbiter model: grant after lat cycles of request, drop with request
    initial bus_gnt = 1'b0;
    always @(negedge clk) begin
        if (!bus_req) begin
            bus_gnt = 1'b0;
            wcnt = 0;
        end else if (wcnt >= lat) begin
            bus_gnt = 1'b1;
        end else begin
            wcnt++;
        end
    end

    // Bus monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req) req_seen = 1'b1;
            if (prev_xfer) chk("R3 request dropped after word", {31'd0, bus_req}, 32'd0);
            if (bus_xfer) begin
                chk("R2 grant present in word cycle", {31'd0, bus_gnt}, 32'd1);
                chk("R4 word address", {16'd0, bus_mem_addr}, {16'd0, exp_addr});
                chk("R12 device number", {24'd0, bus_dev_addr}, {24'd0, exp_dev});
                chk("R12 direction", {31'd0, bus_mem_to_dev}, {31'd0, exp_dir});
                exp_addr = exp_addr + 16'd1;
                xfer_cnt++;
            end
            prev_xfer = bus_xfer;
        end
    end

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary_and_end();
    end

    initial begin
        logic [15:0] rd;
        logic [15:0] v_cnt, v_addr;
        logic [7:0]  v_dev;
        logic        v_dir;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
        chk("R1 bus_xfer", {31'd0, bus_xfer}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        cfg_read(3'd4, rd); chk("R1 status", {16'd0, rd}, 32'd0);
        cfg_read(3'd2, rd); chk("R1 memory address", {16'd0, rd}, 32'd0);
        cfg_read(3'd3, rd); chk("R1 count", {16'd0, rd}, 32'd0);

        // Vector table: R2 R3 R4 R5 R7 R12
        for (int v = 0; v < NVEC; v++) begin
            v_cnt  = VECS[v][44:29];
            v_addr = VECS[v][28:13];
            v_dev  = VECS[v][12:5];
            v_dir  = VECS[v][4];
            lat    = int'(VECS[v][3:0]);
            exp_addr = v_addr; exp_dev = v_dev; exp_dir = v_dir; xfer_cnt = 0;
            cfg_write(3'd3, v_cnt);
            cfg_write(3'd2, v_addr);
            cfg_write(3'd1, {8'd0, v_dev});
            cfg_write(3'd0, {14'd0, v_dir, 1'b1});
            wait_irq();
            chk("R5 irq at end", {31'd0, irq}, 32'd1);
            chk("R5 word count performed", xfer_cnt, 32'(v_cnt));
            cfg_read(3'd4, rd); chk("R5 status done, not busy", {16'd0, rd}, 32'd2);
            cfg_read(3'd2, rd); chk("R4 final address", {16'd0, rd}, {16'd0, v_addr + v_cnt});
            cfg_read(3'd3, rd); chk("R4 final count", {16'd0, rd}, 32'd0);
            cfg_read(3'd0, rd); chk("R12 direction readback", {16'd0, rd}, {30'd0, v_dir, 1'b0});
            repeat (3) @(negedge clk);
            chk("R6 irq held", {31'd0, irq}, 32'd1);
            cfg_write(3'd4, 16'h0002);
            chk("R7 clear removes irq", {31'd0, irq}, 32'd0);
        end

        // R7: status write without bit 1 keeps done
        lat = 0; exp_addr = 16'h0050; exp_dev = 8'h09; exp_dir = 1'b0; xfer_cnt = 0;
        cfg_write(3'd3, 16'd1);
        cfg_write(3'd2, 16'h0050);
        cfg_write(3'd1, 16'h0009);
        cfg_write(3'd0, 16'h0001);
        wait_irq();
        cfg_write(3'd4, 16'h0001);
        chk("R7 write without clear bit keeps irq", {31'd0, irq}, 32'd1);
        cfg_write(3'd4, 16'h0002);
        chk("R7 clear bit removes irq", {31'd0, irq}, 32'd0);

        // R8: writes during a transfer are ignored
        lat = 6; exp_addr = 16'h0400; exp_dev = 8'h11; exp_dir = 1'b0; xfer_cnt = 0;
        cfg_write(3'd3, 16'd3);
        cfg_write(3'd2, 16'h0400);
        cfg_write(3'd1, 16'h0011);
        cfg_write(3'd0, 16'h0001);
        cfg_write(3'd2, 16'h9999);
        cfg_write(3'd1, 16'h0077);
        cfg_write(3'd3, 16'd5);
        cfg_write(3'd0, 16'h0003);
        wait_irq();
        chk("R8 words unchanged by busy writes", xfer_cnt, 32'd3);
        cfg_read(3'd2, rd); chk("R8 address unchanged by busy write", {16'd0, rd}, 32'h0403);
        cfg_read(3'd1, rd); chk("R8 device unchanged by busy write", {16'd0, rd}, 32'h0011);
        cfg_read(3'd0, rd); chk("R8 direction unchanged by busy write", {16'd0, rd}, 32'd0);
        repeat (4) @(negedge clk);
        chk("R8 busy go started nothing", {31'd0, bus_req}, 32'd0);

        // R9: zero count finishes immediately without a request
        cfg_write(3'd4, 16'h0002);
        cfg_write(3'd3, 16'd0);
        req_seen = 1'b0;
        cfg_write(3'd0, 16'h0001);
        chk("R9 zero count done at once", {31'd0, irq}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R9 no request raised", {31'd0, req_seen}, 32'd0);

        // R11: accepted go clears pending done
        lat = 0; exp_addr = 16'h0700; exp_dev = 8'h11; exp_dir = 1'b0; xfer_cnt = 0;
        cfg_write(3'd3, 16'd2);
        cfg_write(3'd2, 16'h0700);
        chk("R11 done still pending before go", {31'd0, irq}, 32'd1);
        cfg_write(3'd0, 16'h0001);
        chk("R11 go clears done", {31'd0, irq}, 32'd0);
        wait_irq();
        chk("R11 transfer completes", xfer_cnt, 32'd2);

        // R10: completion and clear on the same edge
        lat = 0; exp_addr = 16'h0800; xfer_cnt = 0;
        cfg_write(3'd3, 16'd1);
        cfg_write(3'd2, 16'h0800);
        cfg_write(3'd0, 16'h0001);      // go sampled at E0
        @(negedge clk);                 // after E1 (word cycle)
        cfg_write(3'd4, 16'h0002);      // clear sampled at E3, same as completion
        chk("R10 completion beats clear", {31'd0, irq}, 32'd1);
        cfg_write(3'd4, 16'h0002);
        chk("R10 later clear removes irq", {31'd0, irq}, 32'd0);

        summary_and_end();
    end

endmodule